// File: doc/BRIEF.md
# Embedded Sync Video Decoder

This block recovers picture timing from a parallel digital video stream that carries no separate sync wires. Only the pixel clock and the data bus are used: line and frame timing are taken from the timing reference code words embedded in the data. It accepts two stream kinds, chosen by a mode input: 8-bit interlaced standard-definition video on one byte lane, and 16-bit progressive high-definition video with luma and chroma on separate lanes.

The decoder emits one beat per luma sample, pairing it with its chroma sample, and marks the first beat of every active line and of every frame. For interlaced input it weaves the two fields into one progressive frame. It does this by numbering every output line with its row in the woven frame, so a downstream frame store can write the rows in place. A swap input picks which half of the 16-bit bus carries the 8-bit stream. Timing codes that fail their protection bits are counted and otherwise ignored.

Top module: `esv_decoder`

## Requirements
- R1: While reset is held and after its release, before any stream arrives, `pix_valid`, `pix_sol` and `pix_sof` are 0 and `err_cnt` is 0.
- R2: A timing code is the byte run FF, 00, 00, XY on the sync lane. XY is {1, F, V, H, V^H, F^H, F^V, F^V^H}. H=0 marks start of active video and H=1 marks end. Active samples follow a start code with V=0 and stop at the next FF byte. No FF byte is ever output as luma.
- R3: A code whose XY differs from the protected form for its F, V, H bits changes no timing state: no beats follow it. It adds 1 to `err_cnt`, which holds at its all-ones maximum.
- R4: In 8-bit mode the active bytes arrive as chroma, luma, chroma, luma. Each pair gives one beat with `pix_c` set to the first byte and `pix_y` to the second. The beat is presented in the cycle after the luma byte.
- R5: In 8-bit mode with `byte_swap`=0 the stream is read from `din[7:0]`; with `byte_swap`=1 it is read from `din[15:8]`. The other byte has no effect on the output.
- R6: In 8-bit mode `pix_line` = 2 × (active-line index within the field) + F, and `pix_field` = F. The active-line index restarts at 0 on an end code with V=1.
- R7: In 8-bit mode `pix_sof` is 1 on the first beat of the first active line after a valid code shows F changing from 1 to 0. No other beat has `pix_sof` set.
- R8: In 16-bit mode (`mode_hd`=1) every active cycle gives a beat with `pix_y`=`din[15:8]` and `pix_c`=`din[7:0]`. Codes are searched for on `din[15:8]` only, and `pix_line` is the plain active-line index.
- R9: In 16-bit mode `pix_sof` is 1 on the first beat of the first active line after a valid code shows V changing from 1 to 0.
- R10: `pix_sol` is 1 on the first beat of every active line and on no other beat. `pix_sof` is only ever set together with `pix_sol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_hd | input | 1 | 0: 8-bit interlaced, 1: 16-bit progressive |
| byte_swap | input | 1 | 8-bit mode: take the stream from the upper byte |
| din | input | 16 | Video data bus |
| pix_valid | output | 1 | Output beat present |
| pix_y | output | 8 | Luma sample |
| pix_c | output | 8 | Chroma sample (alternating Cb/Cr) |
| pix_sol | output | 1 | First beat of an active line |
| pix_sof | output | 1 | First beat of a frame |
| pix_field | output | 1 | Field bit of the current line |
| pix_line | output | LINE_W | Row in the progressive output frame |
| err_cnt | output | ERR_W | Saturating count of corrupted codes |

## Verification
Start of frame and start of line fall on the same beat. A frame start is set pending by a code in the blanking area, but it may only come out on the first beat of the next active line. Both the interlaced field-bit edge and the progressive blanking edge are provoked with whole frames, and every beat's flags, row and samples are compared to a model list the bench builds while sending. A corrupted start code that is followed by video-like bytes is also sent. It is judged by the absence of beats and by a counter step of one. Fake code runs on the ignored byte lane show that they do not start a line.

// File: rtl/esv_pkg.sv
package esv_pkg;

  typedef struct packed {
    logic f;
    logic v;
    logic h;
  } esv_code_t;

  localparam logic [7:0] ESV_PRE_HI = 8'hFF;
  localparam logic [7:0] ESV_PRE_LO = 8'h00;

  // protected form of a timing word for a given flag set
  function automatic logic [7:0] esv_xy(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

endpackage

// File: rtl/esv_lane_sel.sv
module esv_lane_sel (
  input  logic        mode_hd,
  input  logic        byte_swap,
  input  logic [15:0] din,
  output logic [7:0]  sync_lane,
  output logic [7:0]  c_lane
);

  always_comb begin
    if (mode_hd) begin
      sync_lane = din[15:8];
      c_lane    = din[7:0];
    end else begin
      sync_lane = byte_swap ? din[15:8] : din[7:0];
      c_lane    = sync_lane;
    end
  end

endmodule

// File: rtl/esv_trs_det.sv
module esv_trs_det
  import esv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [7:0] lane,
  output logic       hit,
  output logic       ok,
  output esv_code_t  code
);

  logic [7:0] d1_q, d2_q, d3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d1_q <= 8'h0;
      d2_q <= 8'h0;
      d3_q <= 8'h0;
    end else if (en) begin
      d1_q <= lane;
      d2_q <= d1_q;
      d3_q <= d2_q;
    end
  end

  always_comb begin
    hit  = (d3_q == ESV_PRE_HI) && (d2_q == ESV_PRE_LO) && (d1_q == ESV_PRE_LO);
    code = '{f: lane[6], v: lane[5], h: lane[4]};
    ok   = (lane == esv_xy(lane[6], lane[5], lane[4]));
  end

endmodule

// File: rtl/esv_decoder.sv
module esv_decoder
  import esv_pkg::*;
#(
  parameter int LINE_W = 11,
  parameter int ERR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_hd,
  input  logic              byte_swap,
  input  logic [15:0]       din,
  output logic              pix_valid,
  output logic [7:0]        pix_y,
  output logic [7:0]        pix_c,
  output logic              pix_sol,
  output logic              pix_sof,
  output logic              pix_field,
  output logic [LINE_W-1:0] pix_line,
  output logic [ERR_W-1:0]  err_cnt
);

  localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};

  // reset: asserted asynchronously, released on the clock
  logic rs1_q, rs2_q, rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_i_n = rs2_q;

  logic [7:0] sync_lane, c_lane;
  logic       hit, ok;
  esv_code_t  code;

  esv_lane_sel u_lane (
    .mode_hd   (mode_hd),
    .byte_swap (byte_swap),
    .din       (din),
    .sync_lane (sync_lane),
    .c_lane    (c_lane)
  );

  esv_trs_det u_det (
    .clk   (clk),
    .rst_n (rst_i_n),
    .en    (1'b1),
    .lane  (sync_lane),
    .hit   (hit),
    .ok    (ok),
    .code  (code)
  );

  // tracker state
  logic              f_q, v_q, act_q, ph_q, sofp_q, solp_q;
  logic              f_n, v_n, act_n, ph_n, sofp_n, solp_n;
  logic [7:0]        ch_q, ch_n;
  logic [LINE_W-1:0] fl_q, fl_n;
  logic [ERR_W-1:0]  err_q, err_n;
  // output stage next values
  logic              ov_n, osol_n, osof_n, ofld_n;
  logic [7:0]        oy_n, oc_n;
  logic [LINE_W-1:0] oln_n;

  always_comb begin
    f_n    = f_q;
    v_n    = v_q;
    act_n  = act_q;
    ph_n   = ph_q;
    sofp_n = sofp_q;
    solp_n = solp_q;
    ch_n   = ch_q;
    fl_n   = fl_q;
    err_n  = err_q;
    ov_n   = 1'b0;
    osol_n = 1'b0;
    osof_n = 1'b0;
    oy_n   = sync_lane;
    oc_n   = mode_hd ? c_lane : ch_q;
    ofld_n = f_q;
    oln_n  = mode_hd ? fl_q : {fl_q[LINE_W-2:0], f_q};

    if (hit) begin
      if (!ok) begin
        if (err_q != ERR_MAX) err_n = err_q + 1'b1;
      end else begin
        f_n = code.f;
        v_n = code.v;
        if (mode_hd ? (v_q && !code.v) : (f_q && !code.f)) sofp_n = 1'b1;
        if (code.h) begin
          act_n = 1'b0;
          fl_n  = code.v ? '0 : fl_q + 1'b1;
        end else begin
          act_n = !code.v;
          ph_n  = 1'b0;
          if (!code.v) solp_n = 1'b1;
        end
      end
    end else if (act_q) begin
      if (sync_lane == ESV_PRE_HI) begin
        act_n = 1'b0;
      end else if (mode_hd || ph_q) begin
        ov_n   = 1'b1;
        osol_n = solp_q;
        osof_n = solp_q & sofp_q;
        solp_n = 1'b0;
        if (solp_q) sofp_n = 1'b0;
        ph_n   = 1'b0;
      end else begin
        ch_n = sync_lane;
        ph_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      f_q    <= 1'b0;
      v_q    <= 1'b0;
      act_q  <= 1'b0;
      ph_q   <= 1'b0;
      sofp_q <= 1'b0;
      solp_q <= 1'b0;
      ch_q   <= 8'h0;
      fl_q   <= '0;
      err_q  <= '0;
    end else begin
      f_q    <= f_n;
      v_q    <= v_n;
      act_q  <= act_n;
      ph_q   <= ph_n;
      sofp_q <= sofp_n;
      solp_q <= solp_n;
      ch_q   <= ch_n;
      fl_q   <= fl_n;
      err_q  <= err_n;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      pix_valid <= 1'b0;
      pix_sol   <= 1'b0;
      pix_sof   <= 1'b0;
      pix_y     <= 8'h0;
      pix_c     <= 8'h0;
      pix_field <= 1'b0;
      pix_line  <= '0;
    end else begin
      pix_valid <= ov_n;
      pix_sol   <= osol_n;
      pix_sof   <= osof_n;
      if (ov_n) begin
        pix_y     <= oy_n;
        pix_c     <= oc_n;
        pix_field <= ofld_n;
        pix_line  <= oln_n;
      end
    end
  end

  assign err_cnt = err_q;

endmodule

// File: rtl/esv_decoder_chk.sv
module esv_decoder_chk #(
  parameter int LINE_W = 11,
  parameter int ERR_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_hd,
  input logic              pix_valid,
  input logic [7:0]        pix_y,
  input logic              pix_sol,
  input logic              pix_sof,
  input logic              pix_field,
  input logic [LINE_W-1:0] pix_line,
  input logic [ERR_W-1:0]  err_cnt
);

  p_sol_on_beat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pix_sol |-> pix_valid);

  p_sof_with_sol_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pix_sof |-> pix_sol);

  p_no_pre_luma_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> (pix_y != 8'hFF));

  p_weave_row_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !mode_hd) |-> (pix_line[0] == pix_field));

  p_err_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((err_cnt == $past(err_cnt)) || (err_cnt == $past(err_cnt) + 1'b1)));

  p_err_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt == {ERR_W{1'b1}}) |=> (err_cnt == {ERR_W{1'b1}}));

endmodule

bind esv_decoder esv_decoder_chk #(.LINE_W(LINE_W), .ERR_W(ERR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_hd   (mode_hd),
  .pix_valid (pix_valid),
  .pix_y     (pix_y),
  .pix_sol   (pix_sol),
  .pix_sof   (pix_sof),
  .pix_field (pix_field),
  .pix_line  (pix_line),
  .err_cnt   (err_cnt)
);

// File: tb/esv_decoder_bench.sv
`timescale 1ns/1ps
module esv_decoder_bench;
  localparam int LW = 11;
  localparam int EW = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, mode_hd, byte_swap;
  logic [15:0]   din;
  logic          pix_valid, pix_sol, pix_sof, pix_field;
  logic [7:0]    pix_y, pix_c;
  logic [LW-1:0] pix_line;
  logic [EW-1:0] err_cnt;

  esv_decoder #(.LINE_W(LW), .ERR_W(EW)) u_esv_decoder (
    .clk(clk), .rst_n(rst_n), .mode_hd(mode_hd), .byte_swap(byte_swap), .din(din),
    .pix_valid(pix_valid), .pix_y(pix_y), .pix_c(pix_c), .pix_sol(pix_sol),
    .pix_sof(pix_sof), .pix_field(pix_field), .pix_line(pix_line), .err_cnt(err_cnt)
  );

  int checks = 0, errors = 0, seq = 0, wr = 0, rd = 0;
  bit mon_on = 1'b0;
  logic [7:0] junk = 8'hFF;
  logic [7:0]    ey [0:1023];
  logic [7:0]    ec [0:1023];
  logic          es [0:1023];
  logic          ef [0:1023];
  logic          efl[0:1023];
  logic [LW-1:0] eln[0:1023];

  task automatic chk(input bit good, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
  end

  // beat monitor against the model list (R4 R6 R7 R8 R9 R10)
  always @(negedge clk) begin
    if (mon_on && pix_valid) begin
      if (rd >= wr) begin
        chk(1'b0, "R3", "unexpected beat", pix_y, 0);
      end else begin
        chk(pix_y == ey[rd], "R4", "luma", pix_y, ey[rd]);
        chk(pix_c == ec[rd], "R8", "chroma", pix_c, ec[rd]);
        chk(pix_sol == es[rd], "R10", "line start", pix_sol, es[rd]);
        chk(pix_sof == ef[rd], "R7", "frame start", pix_sof, ef[rd]);
        chk(pix_field == efl[rd], "R6", "field", pix_field, efl[rd]);
        chk(pix_line == eln[rd], "R6", "row", pix_line, eln[rd]);
        rd++;
      end
    end
  end

  task automatic push(input logic [7:0] y, input logic [7:0] c, input logic sl,
                      input logic sf, input int ln, input logic fl);
    ey[wr] = y; ec[wr] = c; es[wr] = sl; ef[wr] = sf; efl[wr] = fl; eln[wr] = LW'(ln);
    wr++;
  endtask

  task automatic next_px(output logic [7:0] y, output logic [7:0] c);
    seq++;
    y = 8'(16 + (seq % 200));
    c = 8'(20 + ((seq * 7) % 200));
  endtask

  function automatic logic [7:0] xy(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  task automatic put8(input logic [7:0] b);
    @(negedge clk);
    junk = ~junk;
    din <= byte_swap ? {b, junk} : {junk, b};
  endtask

  task automatic put16(input logic [7:0] y, input logic [7:0] c);
    @(negedge clk);
    din <= {y, c};
  endtask

  task automatic code8(input logic f, input logic v, input logic h, input bit bad);
    put8(8'hFF); put8(8'h00); put8(8'h00);
    put8(xy(f, v, h) ^ {7'b0, bad});
  endtask

  task automatic code16(input logic f, input logic v, input logic h);
    put16(8'hFF, 8'hFF); put16(8'h00, 8'h00); put16(8'h00, 8'h00);
    put16(xy(f, v, h), xy(f, v, h));
  endtask

  task automatic line8(input logic f, input logic v, input int idx, input bit sof);
    logic [7:0] y, c;
    code8(f, v, 1'b0, 1'b0);
    for (int p = 0; p < 4; p++) begin
      if (!v) begin
        next_px(y, c);
        push(y, c, p == 0, sof && p == 0, 2 * idx + int'(f), f);
        put8(c); put8(y);
      end else begin
        put8(8'h80); put8(8'h10);
      end
    end
    code8(f, v, 1'b1, 1'b0);
    put8(8'h80); put8(8'h10);
  endtask

  task automatic field8(input logic f, input bit sof);
    for (int b = 0; b < 2; b++) line8(f, 1'b1, 0, 1'b0);
    for (int i = 0; i < 3; i++) line8(f, 1'b0, i, sof && i == 0);
  endtask

  task automatic frame16(input bit fake);
    logic [7:0] y, c;
    for (int b = 0; b < 2; b++) begin
      code16(1'b0, 1'b1, 1'b0);
      if (fake) begin
        // a start code on the chroma lane only must be ignored (R8)
        put16(8'h10, 8'hFF); put16(8'h10, 8'h00);
        put16(8'h10, 8'h00); put16(8'h10, xy(1'b0, 1'b0, 1'b0));
      end else begin
        for (int k = 0; k < 4; k++) put16(8'h10, 8'h80);
      end
      for (int k = 0; k < 3; k++) put16(8'h10, 8'h80);
      code16(1'b0, 1'b1, 1'b1);
      put16(8'h10, 8'h80);
    end
    for (int i = 0; i < 3; i++) begin
      code16(1'b0, 1'b0, 1'b0);
      for (int p = 0; p < 4; p++) begin
        next_px(y, c);
        push(y, c, p == 0, i == 0 && p == 0, i, 1'b0);
        put16(y, c);
      end
      code16(1'b0, 1'b0, 1'b1);
      put16(8'h10, 8'h80); put16(8'h10, 8'h80);
    end
  endtask

  task automatic drain(input string req);
    repeat (6) @(negedge clk);
    chk(rd == wr, req, "beats seen", rd, wr);
  endtask

  initial begin
    int e0, b0;
    rst_n = 1'b0; mode_hd = 1'b0; byte_swap = 1'b0; din = 16'h0;
    repeat (4) @(negedge clk);
    chk(pix_valid == 1'b0, "R1", "valid in reset", pix_valid, 0);
    chk(err_cnt == 0, "R1", "errors in reset", err_cnt, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(pix_valid == 1'b0 && pix_sol == 1'b0 && pix_sof == 1'b0, "R1",
        "flags after reset", {pix_valid, pix_sol, pix_sof}, 0);
    chk(err_cnt == 0, "R1", "errors after reset", err_cnt, 0);
    mon_on = 1'b1;

    // R2 R4 R6 R7 R10: two woven frames on the low lane
    field8(1'b1, 1'b0); field8(1'b0, 1'b1);
    field8(1'b1, 1'b0); field8(1'b0, 1'b1);
    drain("R4");

    // R5: stream on the upper lane, toggling junk below
    byte_swap = 1'b1;
    field8(1'b1, 1'b0); field8(1'b0, 1'b1);
    drain("R5");
    byte_swap = 1'b0;

    // R3: corrupted start code followed by sample-like bytes
    e0 = int'(err_cnt); b0 = wr;
    code8(1'b0, 1'b0, 1'b0, 1'b1);
    for (int k = 0; k < 8; k++) put8(8'h40 + 8'(k));
    code8(1'b0, 1'b1, 1'b1, 1'b0);
    drain("R3");
    chk(int'(err_cnt) == e0 + 1, "R3", "error count step", err_cnt, e0 + 1);
    chk(wr == b0, "R3", "no beats expected", wr, b0);

    // R3: saturation
    for (int k = 0; k < 20; k++) code8(1'b1, 1'b1, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    chk(int'(err_cnt) == 15, "R3", "error count saturates", err_cnt, 15);

    // R8 R9: progressive 16-bit frames
    mode_hd = 1'b1;
    frame16(1'b1);
    frame16(1'b0);
    drain("R9");
    chk(int'(err_cnt) == 15, "R8", "no new errors", err_cnt, 15);

    summary();
  end

endmodule